// File: doc/BRIEF.md
# Prefix-Extended Immediate XOR Execute Stage

This block is the execute stage of a 32-bit core with sixteen general registers. It takes in one 16-bit instruction word per clock. Only two kinds of word are acted on. A prefix word, flagged by a decoded input, carries a 13-bit immediate chunk. The register XOR instruction combines two registers. When prefix words come directly before it, it instead combines a source register with a zero-extended immediate built from their chunks.

The stage holds at most the two most recent chunks. It forms a 13-bit or 26-bit operand from them, computes the XOR in the same cycle and writes the result into its internal 16 x 32 register file. It also updates its condition flags. A registered write-back report (valid, destination, data) and the registered flags are the observable results. A delay-slot input forces the plain register-register form, so that a pending immediate is never spent on an instruction that follows a delayed branch.

Top module: `xor_ext_stage`

## Requirements
- R1: While `rst` is high at a clock edge, all registers become zero, `wb_valid_o` goes low and `flags_o` becomes 4'b0000 on that edge.
- R2: An accepted word with `is_ext_i` low and bits 15:8 equal to 8'h3A is an XOR. Bits 7:4 name rs and bits 3:0 name rd. With no pending chunk, rd receives rd XOR rs.
- R3: With exactly one pending chunk c, the XOR writes rs XOR zero-extended c to rd. rs keeps its value unless rs equals rd.
- R4: With two pending chunks, the older chunk supplies immediate bits 25:13 and the newer supplies bits 12:0. rd receives rs XOR the zero-extended 26-bit value. Chunks 0x1 then 0x1FFF give an immediate of 0x00003FFF.
- R5: An accepted word with `is_ext_i` high adds its bits 12:0 as the newest chunk. A third consecutive prefix discards the oldest chunk.
- R6: An XOR accepted with `delay_slot_i` high ignores any pending chunks and writes rd XOR rs.
- R7: After every XOR, the flags `flags_o` = {C,V,Z,N} (bit 3 down to bit 0) hold N = result bit 31, Z = (result == 0), V = 0, and C unchanged.
- R8: An accepted non-prefix word that is not an XOR writes no register, leaves `flags_o` unchanged and gives `wb_valid_o` low.
- R9: Pending chunks are cleared by every accepted non-prefix word, whether or not it is an XOR, and by reset. They survive cycles in which `valid_i` is low.
- R10: An XOR accepted at edge k is reported on `wb_valid_o`, `wb_rd_o` and `wb_data_o` right after edge k, and the register file holds the value for a read in the next cycle. In all other cycles `wb_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Instruction word is presented this cycle |
| instr_i | input | 16 | Instruction word |
| is_ext_i | input | 1 | Word is an immediate prefix |
| delay_slot_i | input | 1 | Word sits in a delayed-branch slot |
| wb_valid_o | output | 1 | A register was written on the last edge |
| wb_rd_o | output | 4 | Destination register of that write |
| wb_data_o | output | 32 | Value written |
| flags_o | output | 4 | Condition flags {C,V,Z,N} |

## Verification
The hardest states to reach from the ports are a pending-chunk history that has been changed in the middle of a sequence. Examples are a third prefix that pushes out the oldest chunk, chunks that wait across idle cycles, and chunks that are silently dropped by a delay-slot XOR or by an unrelated instruction. Directed sequences place each such history directly before an XOR whose source register already holds a known non-zero value. The destination value then shows which chunks were used. A long random phase biased towards prefix words mixes these histories together. A behavioural model keeps the chunks in a queue and compares the results on every clock.

// File: rtl/xor_ext_pkg.sv
package xor_ext_pkg;

  localparam logic [7:0] XOR_OPCODE = 8'h3A;

  typedef enum logic [1:0] {
    IMM_NONE  = 2'd0,
    IMM_SHORT = 2'd1,
    IMM_LONG  = 2'd2
  } imm_kind_e;

  typedef struct packed {
    logic c;
    logic v;
    logic z;
    logic n;
  } flags_t;

endpackage

// File: rtl/xor_ext_prefix.sv
module xor_ext_prefix
  import xor_ext_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CHUNK_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic              clear_i,
  input  logic [CHUNK_W-1:0] chunk_i,
  output imm_kind_e         kind_o,
  output logic [DATA_W-1:0] imm_o
);

  localparam int PAD_SHORT = DATA_W - CHUNK_W;
  localparam int PAD_LONG  = DATA_W - 2 * CHUNK_W;

  logic [CHUNK_W-1:0] older_q, newer_q;
  imm_kind_e          kind_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      older_q <= '0;
      newer_q <= '0;
      kind_q  <= IMM_NONE;
    end else if (push_i) begin
      older_q <= newer_q;
      newer_q <= chunk_i;
      kind_q  <= (kind_q == IMM_NONE) ? IMM_SHORT : IMM_LONG;
    end else if (clear_i) begin
      kind_q  <= IMM_NONE;
    end
  end

  always_comb begin
    unique case (kind_q)
      IMM_SHORT: imm_o = {{PAD_SHORT{1'b0}}, newer_q};
      IMM_LONG:  imm_o = {{PAD_LONG{1'b0}}, older_q, newer_q};
      default:   imm_o = '0;
    endcase
  end

  assign kind_o = kind_q;

endmodule

// File: rtl/xor_ext_regfile.sv
module xor_ext_regfile #(
  parameter int DATA_W = 32,
  parameter int REG_N  = 16,
  localparam int ADDR_W = $clog2(REG_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ra_i,
  output logic [DATA_W-1:0] ra_data_o,
  input  logic [ADDR_W-1:0] rb_i,
  output logic [DATA_W-1:0] rb_data_o,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wa_i,
  input  logic [DATA_W-1:0] wd_i
);

  logic [DATA_W-1:0] mem_q [REG_N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REG_N; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[wa_i] <= wd_i;
    end
  end

  assign ra_data_o = mem_q[ra_i];
  assign rb_data_o = mem_q[rb_i];

endmodule

// File: rtl/xor_ext_alu.sv
module xor_ext_alu
  import xor_ext_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] rd_val_i,
  input  logic [DATA_W-1:0] rs_val_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic              use_imm_i,
  input  flags_t            flags_i,
  output logic [DATA_W-1:0] result_o,
  output flags_t            flags_o
);

  logic [DATA_W-1:0] lhs;

  assign lhs      = use_imm_i ? imm_i : rd_val_i;
  assign result_o = lhs ^ rs_val_i;

  always_comb begin
    flags_o   = flags_i;
    flags_o.v = 1'b0;
    flags_o.z = (result_o == '0);
    flags_o.n = result_o[DATA_W-1];
  end

endmodule

// File: rtl/xor_ext_stage.sv
module xor_ext_stage
  import xor_ext_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int REG_N   = 16,
  parameter int CHUNK_W = 13,
  parameter int INSTR_W = 16,
  localparam int ADDR_W = $clog2(REG_N)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               is_ext_i,
  input  logic               delay_slot_i,
  output logic               wb_valid_o,
  output logic [ADDR_W-1:0]  wb_rd_o,
  output logic [DATA_W-1:0]  wb_data_o,
  output logic [3:0]         flags_o
);

  localparam int RS_LSB = ADDR_W;
  localparam int OP_LSB = 2 * ADDR_W;
  localparam int OP_W   = INSTR_W - OP_LSB;

  logic              take_prefix, take_other, take_xor;
  logic [ADDR_W-1:0] rs_sel, rd_sel;
  logic [DATA_W-1:0] rs_val, rd_val, imm_val, result;
  imm_kind_e         kind;
  logic              use_imm;
  flags_t            flags_q, flags_nxt;

  assign take_prefix = valid_i && is_ext_i;
  assign take_other  = valid_i && !is_ext_i;
  assign take_xor    = take_other && (instr_i[INSTR_W-1:OP_LSB] == OP_W'(XOR_OPCODE));
  assign rs_sel      = instr_i[RS_LSB +: ADDR_W];
  assign rd_sel      = instr_i[0 +: ADDR_W];

  xor_ext_prefix #(.DATA_W(DATA_W), .CHUNK_W(CHUNK_W)) u_pfx (
    .clk     (clk),
    .rst     (rst),
    .push_i  (take_prefix),
    .clear_i (take_other),
    .chunk_i (instr_i[CHUNK_W-1:0]),
    .kind_o  (kind),
    .imm_o   (imm_val)
  );

  xor_ext_regfile #(.DATA_W(DATA_W), .REG_N(REG_N)) u_rf (
    .clk       (clk),
    .rst       (rst),
    .ra_i      (rs_sel),
    .ra_data_o (rs_val),
    .rb_i      (rd_sel),
    .rb_data_o (rd_val),
    .we_i      (take_xor),
    .wa_i      (rd_sel),
    .wd_i      (result)
  );

  assign use_imm = (kind != IMM_NONE) && !delay_slot_i;

  xor_ext_alu #(.DATA_W(DATA_W)) u_alu (
    .rd_val_i  (rd_val),
    .rs_val_i  (rs_val),
    .imm_i     (imm_val),
    .use_imm_i (use_imm),
    .flags_i   (flags_q),
    .result_o  (result),
    .flags_o   (flags_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid_o <= 1'b0;
      wb_rd_o    <= '0;
      wb_data_o  <= '0;
      flags_q    <= '0;
    end else begin
      wb_valid_o <= take_xor;
      if (take_xor) begin
        wb_rd_o   <= rd_sel;
        wb_data_o <= result;
        flags_q   <= flags_nxt;
      end
    end
  end

  assign flags_o = flags_q;

endmodule

// File: rtl/xor_ext_checker.sv
module xor_ext_checker #(
  parameter int DATA_W  = 32,
  parameter int INSTR_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               valid_i,
  input logic               is_ext_i,
  input logic [INSTR_W-1:0] instr_i,
  input logic               wb_valid_o,
  input logic [DATA_W-1:0]  wb_data_o,
  input logic [3:0]         flags_o
);

  logic is_xor_word;
  assign is_xor_word = valid_i && !is_ext_i && (instr_i[INSTR_W-1:INSTR_W-8] == 8'h3A);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!wb_valid_o && flags_o == 4'b0000));

  a_r7_v_clear: assert property (@(posedge clk) disable iff (rst)
    wb_valid_o |-> !flags_o[2]);

  a_r7_z_tracks: assert property (@(posedge clk) disable iff (rst)
    wb_valid_o |-> (flags_o[1] == (wb_data_o == '0)));

  a_r7_n_tracks: assert property (@(posedge clk) disable iff (rst)
    wb_valid_o |-> (flags_o[0] == wb_data_o[DATA_W-1]));

  a_r8_flags_hold: assert property (@(posedge clk) disable iff (rst)
    !wb_valid_o |-> $stable(flags_o));

  a_r10_wb_follows: assert property (@(posedge clk) disable iff (rst)
    is_xor_word |=> wb_valid_o);

  a_r10_wb_quiet: assert property (@(posedge clk) disable iff (rst)
    !is_xor_word |=> !wb_valid_o);

endmodule

bind xor_ext_stage xor_ext_checker #(.DATA_W(DATA_W), .INSTR_W(INSTR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .valid_i    (valid_i),
  .is_ext_i   (is_ext_i),
  .instr_i    (instr_i),
  .wb_valid_o (wb_valid_o),
  .wb_data_o  (wb_data_o),
  .flags_o    (flags_o)
);

// File: tb/tb_xor_ext_stage.sv
`timescale 1ns/1ps
module tb_xor_ext_stage;

  logic        clk = 1'b0;
  logic        rst;
  logic        valid_i, is_ext_i, delay_slot_i;
  logic [15:0] instr_i;
  logic        wb_valid_o;
  logic [3:0]  wb_rd_o;
  logic [31:0] wb_data_o;
  logic [3:0]  flags_o;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  xor_ext_stage dut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .instr_i(instr_i),
    .is_ext_i(is_ext_i), .delay_slot_i(delay_slot_i),
    .wb_valid_o(wb_valid_o), .wb_rd_o(wb_rd_o), .wb_data_o(wb_data_o),
    .flags_o(flags_o)
  );

  // behavioural reference
  logic [31:0] m_reg [16];
  logic [12:0] m_q [$];
  logic [3:0]  m_flags;
  logic        e_wbv;
  logic [3:0]  e_rd;
  logic [31:0] e_data;

  function automatic logic [15:0] xw(input int rd, input int rs);
    return {8'h3A, 4'(rs), 4'(rd)};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 16; i++) m_reg[i] = '0;
    m_q.delete();
    m_flags = '0; e_wbv = 0; e_rd = '0; e_data = '0;
  endtask

  task automatic model_step(input logic v, input logic ext, input logic ds, input logic [15:0] w);
    logic [31:0] a, res;
    e_wbv = 0;
    if (v && ext) begin
      m_q.push_back(w[12:0]);
      if (m_q.size() > 2) void'(m_q.pop_front());
    end else if (v) begin
      if (w[15:8] == 8'h3A) begin
        if (ds || m_q.size() == 0) a = m_reg[w[3:0]];
        else if (m_q.size() == 1) a = {19'd0, m_q[0]};
        else a = {6'd0, m_q[0], m_q[1]};
        res = a ^ m_reg[w[7:4]];
        m_reg[w[3:0]] = res;
        m_flags = {m_flags[3], 1'b0, (res == 0), res[31]};
        e_wbv = 1; e_rd = w[3:0]; e_data = res;
      end
      m_q.delete();
    end
  endtask

  task automatic check(input string req, input logic ok, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    check(req, wb_valid_o === e_wbv, "wb_valid", 64'(wb_valid_o), 64'(e_wbv));
    if (e_wbv) begin
      check(req, wb_rd_o === e_rd, "wb_rd", 64'(wb_rd_o), 64'(e_rd));
      check(req, wb_data_o === e_data, "wb_data", 64'(wb_data_o), 64'(e_data));
    end
    check(req, flags_o === m_flags, "flags", 64'(flags_o), 64'(m_flags));
  endtask

  // drive on falling edge, sample just after the next rising edge
  task automatic step(input string req, input logic v, input logic ext,
                      input logic ds, input logic [15:0] w);
    @(negedge clk);
    valid_i = v; is_ext_i = ext; delay_slot_i = ds; instr_i = w;
    model_step(v, ext, ds, w);
    @(posedge clk); #1;
    compare(req);
  endtask

  task automatic pfx(input string req, input int c);
    step(req, 1, 1, 0, 16'(c));
  endtask

  task automatic xo(input string req, input int rd, input int rs, input logic ds = 0);
    step(req, 1, 0, ds, xw(rd, rs));
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst = 1; valid_i = 0; is_ext_i = 0; delay_slot_i = 0; instr_i = '0;
    model_reset();
    repeat (3) @(posedge clk);
    #1; compare("R1");
    @(negedge clk); rst = 0;
    // R1: registers zero -> xor r5,r6 gives zero, Z set
    xo("R1", 5, 6);
    // R4: example 0x1, 0x1FFF -> r1 = r2 ^ 0x3FFF
    pfx("R4", 16'h0001); pfx("R4", 16'h1FFF); xo("R4", 1, 2);
    check("R4", wb_data_o === 32'h0000_3FFF, "example", 64'(wb_data_o), 64'h3FFF);
    // R3: one prefix loads r2, then r3 = r2 ^ imm, r2 untouched
    pfx("R3", 16'h0155); xo("R3", 2, 0);
    pfx("R3", 16'h00AA); xo("R3", 3, 2);
    xo("R3", 4, 2);                      // r4 = r4 ^ r2 shows r2 unchanged
    // R2: plain register form
    xo("R2", 1, 2); xo("R2", 3, 3);
    // R5: three prefixes keep only the newest two
    pfx("R5", 16'h1234); pfx("R5", 16'h0ABC); pfx("R5", 16'h1FFF); xo("R5", 6, 1);
    // R6: delay slot ignores pending chunks, then they are gone
    pfx("R6", 16'h0F0F); pfx("R6", 16'h00F0); xo("R6", 7, 1, 1'b1);
    xo("R6", 8, 1);
    // R8 / R9: unrelated word does not write and clears chunks
    pfx("R8", 16'h0777); step("R8", 1, 0, 0, 16'h1234); xo("R9", 9, 4);
    // R9: chunks survive idle cycles
    pfx("R9", 16'h0003); step("R9", 0, 0, 0, 16'hFFFF); step("R9", 0, 1, 0, 16'h0111);
    pfx("R9", 16'h0004); xo("R9", 10, 0);
    // R10: written value read by the very next instruction
    pfx("R10", 16'h1ABC); xo("R10", 11, 0); xo("R10", 12, 11);
    // R7: Z flag set then cleared, C held
    xo("R7", 12, 12); xo("R7", 12, 1);
    // R5/R2/R6/R8: random mix compared every clock
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 9);
      logic [15:0] w = 16'($urandom);
      if (r < 4)      step("R5", 1, 1, 0, w);
      else if (r < 7) step("R3", 1, 0, logic'(r == 6), xw($urandom_range(0, 15), $urandom_range(0, 15)));
      else if (r < 8) step("R8", 1, 0, 0, {8'h3B, w[7:0]});
      else            step("R9", 0, logic'(w[0]), 0, w);
    end
    // R1: reset mid-sequence drops chunks and registers
    pfx("R1", 16'h0055);
    @(negedge clk); rst = 1; valid_i = 0;
    model_reset();
    @(posedge clk); #1; compare("R1");
    @(negedge clk); rst = 0;
    xo("R1", 2, 3);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule